// File: doc/BRIEF.md
# I2C Transfer Status, Interrupt and NACK Lock

This block holds the status and interrupt state of an I2C master controller. The transfer engine reports events to it as single-cycle pulses: a slave NACK, a STOP put on the bus, a START issued for a read, a write into the transmit holding register, overrun and underrun. It also sees the occupancy of the transmit holding register, the receive holding register and the shift register as live levels. Software acts on it through write strobes for interrupt enable, interrupt disable and the control command word, and through a read strobe on the status word. From these it builds the status word, the readable interrupt mask, the interrupt line, and a DMA transmit request that is gated by the lock.

Completion is a live level, not a latched flag. It is high only when no transfer is open, the transmit holding register is empty and the shifter is idle. A NACK moves the transmit state machine into a locked state. While locked, DMA transmit requests are blocked and the engine is told to hold any transmit data it is given. Only an explicit unlock command or a software reset leaves that state.

The transmit state machine `i2c_sl_lock_fsm` has three states. `TX_IDLE`: no transfer open, STOP done. `TX_BUSY`: a transfer is open and no STOP has been seen yet. `TX_LOCKED`: frozen after a NACK. The transitions are:
- **start**: `TX_IDLE` to `TX_BUSY`, on a START-for-read pulse or a transmit holding write.
- **stop**: `TX_BUSY` to `TX_IDLE`, on STOP sent.
- **nack**: `TX_IDLE` or `TX_BUSY` to `TX_LOCKED`.
- **unlock**: `TX_LOCKED` to `TX_IDLE`, on control bit 26, unless a NACK arrives in the same cycle.
- **reset**: any state to `TX_IDLE`, on control bit 7.

Top module: `i2c_stat_lock`

## Requirements
- R1: After reset, with all holding registers empty and the shifter idle, the status word reads 0x0000_0005 (completion and transmit-ready set). The mask reads 0, the interrupt line is 0 and the lock is clear.
- R2: Status bit 0 (completion) is a level. It is 1 exactly when no transfer is open, the transmit holding register is empty and the shifter is idle. Reading the status word does not clear it.
- R3: A START-for-read pulse or a transmit holding write in the idle state opens a transfer, so bit 0 reads 0 from the next cycle. It returns to 1 only after the STOP-sent pulse, once the holding register and shifter are empty.
- R4: A NACK pulse sets status bit 8 (NACK) and bit 23 (LOCK) in the next cycle. Bit 0 also reads 1 in that cycle when the holding register and shifter are empty.
- R5: While bit 23 is set, `dma_tx_req` is 0 whatever `dma_req_in` is, and `tx_hold` is 1. A transmit holding write while locked opens no transfer, and bit 0 follows only the holding register occupancy.
- R6: Bit 23 is cleared only by a control write with bit 26 set, or with bit 7 set. Other control bits leave it set. A NACK in the same cycle as bit 26 keeps it set.
- R7: A control write with bit 24 set pulses `thr_flush`, and one with bit 25 set pulses `rhr_flush`, in the same cycle as the write.
- R8: Bits 6 (overrun), 7 (underrun) and 8 (NACK) are sticky. A status read strobe clears them in the next cycle. An event in the same cycle as the read keeps its bit set.
- R9: Bit 1 follows `rhr_full`. Bit 2 is the inverse of `thr_full`.
- R10: An enable write sets mask bits and a disable write clears them. Disable wins when both hit the same bit. Only bits 0, 1, 2, 6, 7, 8 and 23 can be set, so an all-ones enable reads back as 0x0080_01C7.
- R11: `irq` is 1 exactly when some status bit and its mask bit are both 1.
- R12: A control write with bit 7 set pulses both flush outputs. From the next cycle it has cleared the sticky flags, the lock and the mask, and the state machine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_nack | input | 1 | Pulse: slave did not acknowledge |
| ev_stop_sent | input | 1 | Pulse: STOP condition completed |
| ev_start_rd | input | 1 | Pulse: START issued for a read |
| ev_ovr | input | 1 | Pulse: receive overrun |
| ev_unr | input | 1 | Pulse: transmit underrun |
| thr_wr | input | 1 | Pulse: transmit holding register written |
| thr_full | input | 1 | Transmit holding register occupied |
| rhr_full | input | 1 | Receive holding register occupied |
| shifter_busy | input | 1 | Shift register active |
| dma_req_in | input | 1 | Raw DMA transmit request from the engine |
| ier_wr | input | 1 | Interrupt-enable write strobe |
| ier_data | input | DATA_W | Bits to enable |
| idr_wr | input | 1 | Interrupt-disable write strobe |
| idr_data | input | DATA_W | Bits to disable |
| cr_wr | input | 1 | Control command write strobe |
| cr_data | input | DATA_W | Command bits (7 reset, 24/25 flush, 26 unlock) |
| sr_rd | input | 1 | Status read strobe |
| status | output | DATA_W | Status word |
| imr | output | DATA_W | Interrupt mask read-back |
| irq | output | 1 | Interrupt line |
| dma_tx_req | output | 1 | Gated DMA transmit request |
| tx_hold | output | 1 | Engine must not shift out held data |
| thr_flush | output | 1 | Flush transmit holding register |
| rhr_flush | output | 1 | Flush receive holding register |

## Verification
A table of event and level patterns is used first. It takes the completion flag through a write transfer, a drain with the shifter still busy but no STOP yet, a STOP, and a read transfer opened by START. This tells the level-type completion apart from a latched one, and tells a drained shifter apart from a finished transfer. The same table then injects a NACK mid-transfer followed by a locked holding write and an underrun. This shows that completion rises with the lock and then drops again on held data while the lock persists. Directed cases then cover the corner cases:
- a flush without unlock;
- an unlock that collides with a NACK;
- a read that collides with a sticky event;
- enable and disable writes to the same mask bit;
- a software reset taken from the locked state.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;

    // Status word bit positions (software decodes these)
    localparam int unsigned BIT_TXCOMP = 0;
    localparam int unsigned BIT_RXRDY  = 1;
    localparam int unsigned BIT_TXRDY  = 2;
    localparam int unsigned BIT_OVRE   = 6;
    localparam int unsigned BIT_UNRE   = 7;
    localparam int unsigned BIT_NACK   = 8;
    localparam int unsigned BIT_LOCK   = 23;

    // Control command bit positions
    localparam int unsigned CMD_SWRST   = 7;
    localparam int unsigned CMD_THRCLR  = 24;
    localparam int unsigned CMD_RHRCLR  = 25;
    localparam int unsigned CMD_LOCKCLR = 26;

    // Sticky flag slots
    localparam int unsigned NUM_STICKY = 3;
    localparam int unsigned SLOT_OVR   = 0;
    localparam int unsigned SLOT_UNR   = 1;
    localparam int unsigned SLOT_NACK  = 2;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_BUSY   = 2'd1,
        TX_LOCKED = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic soft_rst;
        logic flush_tx;
        logic flush_rx;
        logic unlock;
    } ctl_cmd_t;

endpackage

// File: rtl/i2c_sl_lock_fsm.sv
module i2c_sl_lock_fsm
    import i2c_sl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctl_cmd_t cmd,
    input  logic     ev_nack,
    input  logic     ev_stop_sent,
    input  logic     ev_start_rd,
    input  logic     thr_wr,
    output logic     xfer_open,
    output logic     locked
);

    tx_state_e state_q;
    tx_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: nack has priority over stop/start and over unlock
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (ev_nack) begin
                    state_d = TX_LOCKED;
                end else if (ev_start_rd || thr_wr) begin
                    state_d = TX_BUSY;
                end
            end
            TX_BUSY: begin
                if (ev_nack) begin
                    state_d = TX_LOCKED;
                end else if (ev_stop_sent) begin
                    state_d = TX_IDLE;
                end
            end
            TX_LOCKED: begin
                if (cmd.unlock && !ev_nack) begin
                    state_d = TX_IDLE;
                end
            end
            default: begin
                state_d = TX_IDLE;
            end
        endcase
        if (cmd.soft_rst) begin
            state_d = TX_IDLE;
        end
    end

    // Outputs from state
    always_comb begin
        xfer_open = 1'b0;
        locked    = 1'b0;
        unique case (state_q)
            TX_IDLE:   ;
            TX_BUSY:   xfer_open = 1'b1;
            TX_LOCKED: locked    = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/i2c_sl_sticky.sv
module i2c_sl_sticky #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         rd_clr,
    input  logic         soft_rst,
    output logic [N-1:0] flags
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (soft_rst) begin
                flags[i] <= 1'b0;
            end else if (set_ev[i]) begin
                flags[i] <= 1'b1;
            end else if (rd_clr) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_sl_irq_mask.sv
module i2c_sl_irq_mask #(
    parameter int unsigned    W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ier_wr,
    input  logic [W-1:0] ier_data,
    input  logic         idr_wr,
    input  logic [W-1:0] idr_data,
    input  logic         soft_rst,
    input  logic [W-1:0] status,
    output logic [W-1:0] imr,
    output logic         irq
);

    logic [W-1:0] imr_d;

    always_comb begin
        imr_d = imr;
        if (ier_wr) begin
            imr_d = imr_d | (ier_data & IMPL);
        end
        if (idr_wr) begin
            imr_d = imr_d & ~idr_data;
        end
        if (soft_rst) begin
            imr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imr <= '0;
        end else begin
            imr <= imr_d;
        end
    end

    assign irq = |(status & imr);

endmodule

// File: rtl/i2c_stat_lock.sv
module i2c_stat_lock
    import i2c_sl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_nack,
    input  logic              ev_stop_sent,
    input  logic              ev_start_rd,
    input  logic              ev_ovr,
    input  logic              ev_unr,
    input  logic              thr_wr,
    input  logic              thr_full,
    input  logic              rhr_full,
    input  logic              shifter_busy,
    input  logic              dma_req_in,
    input  logic              ier_wr,
    input  logic [DATA_W-1:0] ier_data,
    input  logic              idr_wr,
    input  logic [DATA_W-1:0] idr_data,
    input  logic              cr_wr,
    input  logic [DATA_W-1:0] cr_data,
    input  logic              sr_rd,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] imr,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              tx_hold,
    output logic              thr_flush,
    output logic              rhr_flush
);

    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << BIT_TXCOMP) | (DATA_W'(1) << BIT_RXRDY) |
        (DATA_W'(1) << BIT_TXRDY)  | (DATA_W'(1) << BIT_OVRE)  |
        (DATA_W'(1) << BIT_UNRE)   | (DATA_W'(1) << BIT_NACK)  |
        (DATA_W'(1) << BIT_LOCK);

    ctl_cmd_t              cmd;
    logic                  xfer_open;
    logic                  locked;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky_q;
    logic                  cr_unused;

    // Command decode
    always_comb begin
        cmd.soft_rst = cr_wr && cr_data[CMD_SWRST];
        cmd.flush_tx = cr_wr && cr_data[CMD_THRCLR];
        cmd.flush_rx = cr_wr && cr_data[CMD_RHRCLR];
        cmd.unlock   = cr_wr && cr_data[CMD_LOCKCLR];
    end

    assign cr_unused = ^{cr_data[DATA_W-1:CMD_LOCKCLR+1],
                         cr_data[CMD_THRCLR-1:CMD_SWRST+1],
                         cr_data[CMD_SWRST-1:0]};

    i2c_sl_lock_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .ev_nack      (ev_nack),
        .ev_stop_sent (ev_stop_sent),
        .ev_start_rd  (ev_start_rd),
        .thr_wr       (thr_wr),
        .xfer_open    (xfer_open),
        .locked       (locked)
    );

    always_comb begin
        sticky_set            = '0;
        sticky_set[SLOT_OVR]  = ev_ovr;
        sticky_set[SLOT_UNR]  = ev_unr;
        sticky_set[SLOT_NACK] = ev_nack;
    end

    i2c_sl_sticky #(.N(NUM_STICKY)) i_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (sticky_set),
        .rd_clr   (sr_rd),
        .soft_rst (cmd.soft_rst),
        .flags    (sticky_q)
    );

    // Status word assembly
    always_comb begin
        status             = '0;
        status[BIT_TXCOMP] = !xfer_open && !thr_full && !shifter_busy;
        status[BIT_RXRDY]  = rhr_full;
        status[BIT_TXRDY]  = !thr_full;
        status[BIT_OVRE]   = sticky_q[SLOT_OVR];
        status[BIT_UNRE]   = sticky_q[SLOT_UNR];
        status[BIT_NACK]   = sticky_q[SLOT_NACK];
        status[BIT_LOCK]   = locked;
    end

    i2c_sl_irq_mask #(.W(DATA_W), .IMPL(IMPL_MASK)) i_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .ier_wr   (ier_wr),
        .ier_data (ier_data),
        .idr_wr   (idr_wr),
        .idr_data (idr_data),
        .soft_rst (cmd.soft_rst),
        .status   (status),
        .imr      (imr),
        .irq      (irq)
    );

    assign dma_tx_req = dma_req_in && !locked;
    assign tx_hold    = locked;
    assign thr_flush  = cmd.flush_tx || cmd.soft_rst;
    assign rhr_flush  = cmd.flush_rx || cmd.soft_rst;

endmodule

// File: rtl/i2c_stat_lock_chk.sv
module i2c_stat_lock_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_nack,
    input logic              thr_full,
    input logic              shifter_busy,
    input logic              idr_wr,
    input logic [DATA_W-1:0] idr_data,
    input logic              cr_wr,
    input logic              cr_rst_b,
    input logic              cr_thrclr_b,
    input logic              cr_unlock_b,
    input logic              sr_rd,
    input logic              st_txcomp,
    input logic              st_nack,
    input logic              st_lock,
    input logic [DATA_W-1:0] imr,
    input logic              irq,
    input logic              dma_tx_req,
    input logic              thr_flush
);

    p_txcomp_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_txcomp |-> (!thr_full && !shifter_busy));

    p_nack_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack && !(cr_wr && cr_rst_b)) |=> (st_lock && st_nack));

    p_dma_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_lock |-> !dma_tx_req);

    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_lock && !(cr_wr && (cr_unlock_b || cr_rst_b))) |=> st_lock);

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_thrclr_b) |-> thr_flush);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_nack && !sr_rd && !(cr_wr && cr_rst_b)) |=> st_nack);

    p_mask_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idr_wr |=> ((imr & $past(idr_data)) == '0));

    p_irq_needs_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (imr != '0));

    p_swrst_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_rst_b) |=> ((imr == '0) && !st_lock));

endmodule

bind i2c_stat_lock i2c_stat_lock_chk #(.DATA_W(DATA_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_nack      (ev_nack),
    .thr_full     (thr_full),
    .shifter_busy (shifter_busy),
    .idr_wr       (idr_wr),
    .idr_data     (idr_data),
    .cr_wr        (cr_wr),
    .cr_rst_b     (cr_data[7]),
    .cr_thrclr_b  (cr_data[24]),
    .cr_unlock_b  (cr_data[26]),
    .sr_rd        (sr_rd),
    .st_txcomp    (status[0]),
    .st_nack      (status[8]),
    .st_lock      (status[23]),
    .imr          (imr),
    .irq          (irq),
    .dma_tx_req   (dma_tx_req),
    .thr_flush    (thr_flush)
);

// File: tb/test_i2c_stat_lock.sv
module test_i2c_stat_lock;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ev_nack = 0, ev_stop_sent = 0, ev_start_rd = 0;
    logic         ev_ovr = 0, ev_unr = 0, thr_wr = 0;
    logic         thr_full = 0, rhr_full = 0, shifter_busy = 0, dma_req_in = 0;
    logic         ier_wr = 0, idr_wr = 0, cr_wr = 0, sr_rd = 0;
    logic [W-1:0] ier_data = '0, idr_data = '0, cr_data = '0;
    logic [W-1:0] status, imr;
    logic         irq, dma_tx_req, tx_hold, thr_flush, rhr_flush;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_stat_lock #(.DATA_W(W)) i_i2c_stat_lock (
        .clk(clk), .rst_n(rst_n), .ev_nack(ev_nack), .ev_stop_sent(ev_stop_sent),
        .ev_start_rd(ev_start_rd), .ev_ovr(ev_ovr), .ev_unr(ev_unr), .thr_wr(thr_wr),
        .thr_full(thr_full), .rhr_full(rhr_full), .shifter_busy(shifter_busy),
        .dma_req_in(dma_req_in), .ier_wr(ier_wr), .ier_data(ier_data), .idr_wr(idr_wr),
        .idr_data(idr_data), .cr_wr(cr_wr), .cr_data(cr_data), .sr_rd(sr_rd),
        .status(status), .imr(imr), .irq(irq), .dma_tx_req(dma_tx_req),
        .tx_hold(tx_hold), .thr_flush(thr_flush), .rhr_flush(rhr_flush)
    );

    // Row: {nack, stop, start_rd, thr_wr, thr_full, shifter, ovr, unr, sr_rd, expected status}
    localparam int NVEC = 12;
    localparam logic [40:0] VECS [NVEC] = '{
        {9'b000000000, 32'h0000_0005},  // R2 idle
        {9'b000110000, 32'h0000_0000},  // R3 write opens transfer
        {9'b000001000, 32'h0000_0004},  // R2 shifter busy
        {9'b000000000, 32'h0000_0004},  // R3 drained, no STOP yet
        {9'b010000000, 32'h0000_0005},  // R3 STOP sent
        {9'b001000000, 32'h0000_0004},  // R3 START for read
        {9'b000000100, 32'h0000_0044},  // R8 overrun sticky
        {9'b000000001, 32'h0000_0004},  // R8 read clears
        {9'b100000000, 32'h0080_0105},  // R4 nack: lock, nack, completion
        {9'b000110000, 32'h0080_0100},  // R5 held data drops completion
        {9'b000010010, 32'h0080_0180},  // R8 underrun while locked
        {9'b000010001, 32'h0080_0000}   // R8 read clears, lock stays (R6)
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clr_pulses();
        ev_nack = 0; ev_stop_sent = 0; ev_start_rd = 0; ev_ovr = 0; ev_unr = 0;
        thr_wr = 0; ier_wr = 0; idr_wr = 0; cr_wr = 0; sr_rd = 0;
        ier_data = '0; idr_data = '0; cr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 status", status, 32'h0000_0005);
        chk("R1 imr", imr, '0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tx_hold", {31'd0, tx_hold}, 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            {ev_nack, ev_stop_sent, ev_start_rd, thr_wr, thr_full, shifter_busy,
             ev_ovr, ev_unr, sr_rd} = VECS[i][40:32];
            step();
            chk($sformatf("R2/R3/R4/R5/R8 row %0d", i), status, VECS[i][31:0]);
        end

        // R5 gating while locked
        clr_pulses();
        thr_full = 1; dma_req_in = 1;
        step();
        chk("R5 dma gated", {31'd0, dma_tx_req}, 32'd0);
        chk("R5 tx_hold", {31'd0, tx_hold}, 32'd1);

        // R7 flush tx only, R6 lock survives
        cr_wr = 1; cr_data = 32'h0100_0000;
        #1;
        chk("R7 thr_flush", {31'd0, thr_flush}, 32'd1);
        chk("R7 rhr_flush idle", {31'd0, rhr_flush}, 32'd0);
        step();
        clr_pulses();
        thr_full = 0;
        #1;
        chk("R6 lock after flush, R2 completion", status, 32'h0080_0005);

        // R6 unlock colliding with nack
        cr_wr = 1; cr_data = 32'h0400_0000; ev_nack = 1;
        step();
        clr_pulses();
        chk("R6 nack beats unlock", status, 32'h0080_0105);

        // R8 read colliding with event
        sr_rd = 1; ev_unr = 1;
        step();
        clr_pulses();
        chk("R8 set wins over read", status, 32'h0080_0085);
        sr_rd = 1;
        step();
        clr_pulses();
        chk("R8 read clears", status, 32'h0080_0005);

        // R6 unlock, R7 rx flush
        cr_wr = 1; cr_data = 32'h0600_0000;
        #1;
        chk("R7 rhr_flush", {31'd0, rhr_flush}, 32'd1);
        step();
        clr_pulses();
        chk("R6 unlocked", status, 32'h0000_0005);
        chk("R5 dma passes", {31'd0, dma_tx_req}, 32'd1);

        // R9
        rhr_full = 1;
        #1;
        chk("R9 rxrdy", status, 32'h0000_0007);
        rhr_full = 0;

        // R10 / R11 mask
        ier_wr = 1; ier_data = '1;
        step();
        clr_pulses();
        chk("R10 enable all", imr, 32'h0080_01C7);
        chk("R11 irq on", {31'd0, irq}, 32'd1);
        idr_wr = 1; idr_data = 32'h0000_0005;
        step();
        clr_pulses();
        chk("R10 disable", imr, 32'h0080_01C2);
        chk("R11 irq off", {31'd0, irq}, 32'd0);
        ier_wr = 1; ier_data = 32'h1; idr_wr = 1; idr_data = 32'h1;
        step();
        clr_pulses();
        chk("R10 disable wins", imr, 32'h0080_01C2);
        ev_ovr = 1;
        step();
        clr_pulses();
        chk("R11 irq from overrun", {31'd0, irq}, 32'd1);

        // R12 software reset from locked
        ev_nack = 1;
        step();
        clr_pulses();
        chk("R4 relock", status, 32'h0080_0145);
        cr_wr = 1; cr_data = 32'h0000_0080;
        #1;
        chk("R12 flushes", {30'd0, thr_flush, rhr_flush}, 32'd3);
        step();
        clr_pulses();
        chk("R12 status cleared", status, 32'h0000_0005);
        chk("R12 mask cleared", imr, '0);
        thr_wr = 1; thr_full = 1;
        step();
        clr_pulses();
        thr_full = 0;
        #1;
        chk("R12 fsm idle then busy", status, 32'h0000_0004);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule